// File: doc/BRIEF.md
# Configuration Access Router

The router sits between a configuration requester and a set of function-level configuration register blocks. Each request carries a packed 24-bit address, a byte length and, for writes, up to four data bytes. The address is split into a bus number, a device/function slot and a register offset. The request is then steered to exactly one configuration port, or to none when the addressed bus or slot holds no function.

There are two buses. The primary bus is always bus 0. The secondary bus sits behind one bridge function on the primary bus. The router watches writes aimed at that bridge and learns the secondary bus number from them. The write itself still reaches the bridge's own registers.

Read data comes back one cycle after the request, together with a single-cycle valid strobe. The data is trimmed to the requested length. An absent target answers with all ones of that length, and a write to an absent target is dropped.

Top module: `cfg_access_router`

## Requirements
- R1: Address bits 23:16 are the bus number, 15:8 the slot (device = slot bits 7:3, function = slot bits 2:0) and 7:0 the register offset. A request on bus 0 to slot s < N_PRI whose `fn_present[s]` is set raises `fn_sel[s]` in the same cycle. The request's write flag, offset, length and write data appear on the shared `fn_*` outputs.
- R2: A read to a missing bus or an empty slot returns a value that depends on the length code. Code 1 returns 0x000000FF, code 2 returns 0x0000FFFF, and code 4 or any other code returns 0xFFFFFFFF.
- R3: At most one bit of `fn_sel` is high in any cycle. A write to a missing bus or an empty slot raises no select bit, so no function storage changes.
- R4: A select bit is only ever raised for a port whose presence flag is set.
- R5: The secondary bus number resets to 0, which means no secondary bus is reachable. It changes only on a write that selects the bridge port (slot BRIDGE_SLOT on bus 0).
- R6: A bridge write has three possible effects on the secondary bus number:
  - A write of any length at offset 0x19 sets it to data bits 7:0.
  - A write of length code 2 or more at offset 0x18 sets it to data bits 15:8.
  - A length-1 write at offset 0x18 leaves it unchanged.

  In every case the bridge's own port is still selected for the write.
- R7: A read raises `rsp_valid` for exactly the one cycle after the request. `rsp_rdata` then holds the selected port's `fn_rdata` word, with the bytes beyond the length cleared.
- R8: When the secondary bus number is nonzero, a request on that bus to slot s < N_SEC raises `fn_sel[N_PRI+s]` if that port is present. Any other nonzero bus number is treated as a missing bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, slot and offset |
| req_len | input | 3 | Byte length code: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, byte 0 at the offset |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data trimmed to the length |
| fn_present | input | N_PRI+N_SEC | Presence flag per port |
| fn_sel | output | N_PRI+N_SEC | One-hot select of the addressed port |
| fn_write | output | 1 | Write flag to the ports |
| fn_offset | output | 8 | Register offset to the ports |
| fn_len | output | 3 | Length code to the ports |
| fn_wdata | output | 32 | Write data to the ports |
| fn_rdata | input | 32*(N_PRI+N_SEC) | Combinational read word per port |

## Verification
The bound checker watches several properties on every cycle:
- The select vector stays one-hot or empty.
- Selects only go to present ports.
- Primary-bus slots are routed to their own port.
- The response strobe appears exactly after reads.
- Absent reads return the length-sized all-ones pattern.
- The secondary bus number holds still unless the bridge is written.

Three behaviours need the bench's scenarios:
- Which bridge write lengths and offsets change the bus number, and to what value.
- The rerouting of a bus number to the secondary ports after it changes.
- Data integrity across every slot, length and bus.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 3;

  localparam logic [7:0] OFS_SECBUS_BYTE = 8'h19;
  localparam logic [7:0] OFS_BUSNUM_WORD = 8'h18;

  // byte mask for a length code; unknown codes act as a full word
  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
    case (len)
      3'd1:    len_mask = 32'h0000_00FF;
      3'd2:    len_mask = 32'h0000_FFFF;
      default: len_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_target_decode.sv
module cfg_target_decode #(
  parameter int N_PRI = 4,
  parameter int N_SEC = 4,
  localparam int N_FN = N_PRI + N_SEC
) (
  input  logic [23:0]     addr,
  input  logic [7:0]      sec_bus,
  input  logic [N_FN-1:0] present,
  output logic [N_FN-1:0] sel
);

  logic [7:0] bus_num;
  logic [7:0] slot;
  logic       on_pri;
  logic       on_sec;

  assign bus_num = addr[23:16];
  assign slot    = addr[15:8];
  assign on_pri  = (bus_num == 8'd0);
  assign on_sec  = (sec_bus != 8'd0) && (bus_num == sec_bus);

  for (genvar i = 0; i < N_PRI; i++) begin : g_pri
    assign sel[i] = on_pri && (slot == 8'(i)) && present[i];
  end

  for (genvar j = 0; j < N_SEC; j++) begin : g_sec
    assign sel[N_PRI+j] = on_sec && (slot == 8'(j)) && present[N_PRI+j];
  end

endmodule

// File: rtl/cfg_bridge_snoop.sv
module cfg_bridge_snoop
  import cfg_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bridge_wr,
  input  logic [7:0]        offset,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        sec_bus
);

  logic       cap_en;
  logic [7:0] sec_bus_d;
  logic [7:0] sec_bus_q;

  always_comb begin
    cap_en    = 1'b0;
    sec_bus_d = sec_bus_q;
    if (bridge_wr) begin
      if (offset == OFS_SECBUS_BYTE) begin
        cap_en    = 1'b1;
        sec_bus_d = wdata[7:0];
      end else if (offset == OFS_BUSNUM_WORD && len >= 3'd2) begin
        cap_en    = 1'b1;
        sec_bus_d = wdata[15:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_bus_q <= 8'd0;
    end else if (cap_en) begin
      sec_bus_q <= sec_bus_d;
    end
  end

  assign sec_bus = sec_bus_q;

endmodule

// File: rtl/cfg_read_return.sv
module cfg_read_return
  import cfg_router_pkg::*;
#(
  parameter int N_FN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_req,
  input  logic [N_FN-1:0]        sel,
  input  logic [LEN_W-1:0]       len,
  input  logic [N_FN*DATA_W-1:0] fn_rdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata
);

  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              valid_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_FN; i++) begin
      if (sel[i]) rd_mux = rd_mux | fn_rdata[i*DATA_W +: DATA_W];
    end
    mask    = len_mask(len);
    rdata_d = (|sel) ? (rd_mux & mask) : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_router_pkg::*;
#(
  parameter int N_PRI       = 4,
  parameter int N_SEC       = 4,
  parameter int BRIDGE_SLOT = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [23:0]                        req_addr,
  input  logic [2:0]                         req_len,
  input  logic [31:0]                        req_wdata,
  output logic                               rsp_valid,
  output logic [31:0]                        rsp_rdata,
  input  logic [N_PRI+N_SEC-1:0]             fn_present,
  output logic [N_PRI+N_SEC-1:0]             fn_sel,
  output logic                               fn_write,
  output logic [7:0]                         fn_offset,
  output logic [2:0]                         fn_len,
  output logic [31:0]                        fn_wdata,
  input  logic [(N_PRI+N_SEC)*32-1:0]        fn_rdata
);

  localparam int N_FN = N_PRI + N_SEC;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [7:0]      sec_bus;
  logic [N_FN-1:0] sel_raw;
  logic            bridge_wr;
  logic            rd_req;

  cfg_target_decode #(
    .N_PRI (N_PRI),
    .N_SEC (N_SEC)
  ) u_decode (
    .addr    (req_addr),
    .sec_bus (sec_bus),
    .present (fn_present),
    .sel     (sel_raw)
  );

  assign fn_sel    = req_valid ? sel_raw : '0;
  assign fn_write  = req_write;
  assign fn_offset = req_addr[7:0];
  assign fn_len    = req_len;
  assign fn_wdata  = req_wdata;

  assign bridge_wr = req_valid && req_write && sel_raw[BRIDGE_SLOT];
  assign rd_req    = req_valid && !req_write;

  cfg_bridge_snoop u_snoop (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bridge_wr (bridge_wr),
    .offset    (req_addr[7:0]),
    .len       (req_len),
    .wdata     (req_wdata),
    .sec_bus   (sec_bus)
  );

  cfg_read_return #(
    .N_FN (N_FN)
  ) u_return (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_req    (rd_req),
    .sel       (sel_raw),
    .len       (req_len),
    .fn_rdata  (fn_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/cfg_router_checker.sv
module cfg_router_checker
  import cfg_router_pkg::*;
#(
  parameter int N_PRI       = 4,
  parameter int N_SEC       = 4,
  parameter int BRIDGE_SLOT = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [23:0]            req_addr,
  input logic [2:0]             req_len,
  input logic                   rsp_valid,
  input logic [31:0]            rsp_rdata,
  input logic [N_PRI+N_SEC-1:0] fn_present,
  input logic [N_PRI+N_SEC-1:0] fn_sel,
  input logic [7:0]             sec_bus
);

  localparam int N_FN = N_PRI + N_SEC;

  logic pri_hit;
  assign pri_hit = req_valid && (req_addr[23:16] == 8'd0) &&
                   (req_addr[15:8] < 8'(N_PRI)) &&
                   (((fn_present >> req_addr[15:8]) & N_FN'(1)) != '0);

  assert_pri_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pri_hit |-> (((fn_sel >> req_addr[15:8]) & N_FN'(1)) != '0));

  assert_absent_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && fn_sel == '0) |=> (rsp_rdata == len_mask($past(req_len))));

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_sel));

  assert_sel_present_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel & ~fn_present) == '0);

  assert_secbus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && fn_sel[BRIDGE_SLOT]) |=> $stable(sec_bus));

  assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

endmodule

bind cfg_access_router cfg_router_checker #(
  .N_PRI       (N_PRI),
  .N_SEC       (N_SEC),
  .BRIDGE_SLOT (BRIDGE_SLOT)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .fn_present (fn_present),
  .fn_sel     (fn_sel),
  .sec_bus    (sec_bus)
);

// File: tb/test_cfg_access_router.sv
`timescale 1ns/1ps
module test_cfg_access_router;

  localparam int NP = 4;
  localparam int NS = 4;
  localparam int NF = NP + NS;
  localparam int BR = 1;
  localparam logic [NF-1:0] PRES = 8'b1010_1011;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write;
  logic [23:0] req_addr;
  logic [2:0]  req_len;
  logic [31:0] req_wdata;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NF-1:0] fn_sel;
  logic fn_write;
  logic [7:0] fn_offset;
  logic [2:0] fn_len;
  logic [31:0] fn_wdata;
  logic [NF*32-1:0] fn_rdata;

  always #2 clk = ~clk;

  cfg_access_router #(.N_PRI(NP), .N_SEC(NS), .BRIDGE_SLOT(BR)) i_cfg_access_router (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fn_present(PRES),
    .fn_sel(fn_sel), .fn_write(fn_write), .fn_offset(fn_offset),
    .fn_len(fn_len), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata)
  );

  // per-port register storage driven by the router, and an independent shadow
  logic [7:0] dmem [NF][256];
  logic [7:0] smem [NF][256];
  int n_checks = 0;
  int n_fail = 0;
  int sb = 0;
  bit done = 0;

  function automatic int nbytes(input logic [2:0] len);
    return (len == 3'd1) ? 1 : (len == 3'd2) ? 2 : 4;
  endfunction

  function automatic logic [31:0] ones_for(input logic [2:0] len);
    return (nbytes(len) == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nbytes(len))) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++)
        for (int o = 0; o < 256; o++) dmem[i][o] <= 8'((i * 37 + o * 5) & 255);
    end else begin
      for (int i = 0; i < NF; i++)
        if (fn_sel[i] && fn_write)
          for (int b = 0; b < nbytes(fn_len); b++)
            dmem[i][8'(fn_offset + b)] <= fn_wdata[b*8 +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < NF; i++)
      for (int b = 0; b < 4; b++)
        fn_rdata[i*32 + b*8 +: 8] = dmem[i][8'(fn_offset + b)];
  end

  function automatic int target(input int bus, input int slot);
    if (bus == 0 && slot < NP && PRES[slot]) return slot;
    if (bus != 0 && sb != 0 && bus == sb && slot < NS && PRES[NP+slot]) return NP + slot;
    return -1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input string req, input int bus, input int slot, input int ofs,
                          input logic [2:0] len, input logic [31:0] data);
    int t;
    t = target(bus, slot);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_len = len; req_wdata = data;
    req_addr = {8'(bus), 8'(slot), 8'(ofs)};
    #1;
    check(req, 32'(fn_sel), (t < 0) ? 32'd0 : (32'd1 << t));
    if (t >= 0) begin
      for (int b = 0; b < nbytes(len); b++) smem[t][8'(ofs + b)] = data[b*8 +: 8];
      if (t == BR) begin
        if (ofs == 8'h19) sb = int'(data[7:0]);
        else if (ofs == 8'h18 && len >= 3'd2) sb = int'(data[15:8]);
      end
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic do_read(input string req, input int bus, input int slot, input int ofs,
                         input logic [2:0] len);
    int t;
    logic [31:0] exp;
    t = target(bus, slot);
    if (t < 0) exp = ones_for(len);
    else begin
      exp = '0;
      for (int b = 0; b < 4; b++) exp[b*8 +: 8] = smem[t][8'(ofs + b)];
      exp = exp & ones_for(len);
    end
    @(negedge clk);
    req_valid = 1; req_write = 0; req_len = len; req_wdata = '0;
    req_addr = {8'(bus), 8'(slot), 8'(ofs)};
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check(req, rsp_rdata, exp);
  endtask

  task automatic sweep(input string req, input int bus);
    logic [2:0] lens [3] = '{3'd1, 3'd2, 3'd4};
    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 3; k++) begin
        do_write(req, bus, s, 8'h40 + 4 * k, lens[k],
                 32'hC3A5_0000 ^ 32'((bus << 12) | (s << 4) | k));
        do_read(req, bus, s, 8'h40 + 4 * k, lens[k]);
        do_read(req, bus, s, 8'h40, 3'd4);
      end
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = '0; req_len = 3'd4; req_wdata = '0;
    for (int i = 0; i < NF; i++)
      for (int o = 0; o < 256; o++) smem[i][o] = 8'((i * 37 + o * 5) & 255);
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    check("R7 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R5 reset no select", 32'(fn_sel), 32'd0);

    // R5: with no secondary bus learned, any nonzero bus is missing
    do_read("R5 R2 len1", 5, 0, 8'h00, 3'd1);
    do_read("R2 len2", 5, 1, 8'h00, 3'd2);
    do_read("R2 len4", 200, 3, 8'h10, 3'd4);
    do_read("R2 odd len code", 0, 2, 8'h00, 3'd3);
    do_read("R2 empty slot len1", 0, 2, 8'h04, 3'd1);
    do_write("R3 write empty slot", 0, 2, 8'h40, 3'd4, 32'hDEAD_BEEF);
    do_write("R3 write missing bus", 7, 1, 8'h40, 3'd4, 32'hDEAD_BEEF);

    // R1: primary bus sweep (slots >= NP and absent ones must not route)
    sweep("R1 primary", 0);

    // R6: single byte at 0x19 sets bus 5 and still lands in the bridge
    do_write("R6 byte 0x19", 0, BR, 8'h19, 3'd1, 32'h0000_0005);
    do_read("R6 pass-through", 0, BR, 8'h19, 3'd1);
    sweep("R8 secondary bus 5", 5);
    do_read("R8 other bus missing", 6, 1, 8'h40, 3'd4);
    do_read("R8 primary intact", 0, 3, 8'h40, 3'd4);

    // R6: word at 0x18 takes bits 15:8
    do_write("R6 half 0x18", 0, BR, 8'h18, 3'd2, 32'h0000_0907);
    do_read("R6 old bus gone", 5, 1, 8'h40, 3'd4);
    do_read("R8 new bus 9", 9, 1, 8'h40, 3'd4);
    do_read("R6 pass-through half", 0, BR, 8'h18, 3'd2);

    // R6: byte at 0x18 leaves the number alone
    do_write("R6 byte 0x18 no change", 0, BR, 8'h18, 3'd1, 32'h0000_0033);
    do_read("R6 bus 9 kept", 9, 3, 8'h40, 3'd4);

    // R6: full word at 0x19
    do_write("R6 word 0x19", 0, BR, 8'h19, 3'd4, 32'h1122_330C);
    do_read("R6 bus 12", 12, 3, 8'h40, 3'd2);
    do_read("R6 bus 9 gone", 9, 3, 8'h40, 3'd1);

    // R5: other bridge offsets and other ports do not move it
    do_write("R5 bridge other ofs", 0, BR, 8'h1A, 3'd4, 32'h0000_0707);
    do_write("R5 other port 0x19", 0, 0, 8'h19, 3'd1, 32'h0000_0004);
    do_read("R5 bus 12 kept", 12, 1, 8'h44, 3'd4);
    do_read("R5 bus 4 missing", 4, 1, 8'h44, 3'd4);

    // R8: secondary cleared back to zero
    do_write("R8 clear secondary", 0, BR, 8'h19, 3'd1, 32'h0000_0000);
    do_read("R8 bus 12 missing", 12, 1, 8'h40, 3'd4);
    do_read("R8 primary after clear", 0, 1, 8'h40, 3'd4);

    @(negedge clk);
    check("R7 strobe single cycle", 32'(rsp_valid), 32'd0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule